// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Pin Interrupts

This block is a general-purpose pin port of up to 32 lines, reached through a simple word-wide slave bus with cycle, strobe, write-enable and byte-lane selects. Software sets the value each pin drives and whether its driver is enabled. It can also hand any single output over to a companion hardware signal. It reads back the pin levels and receives a single interrupt line when selected pins meet their trigger condition.

Input pins are normally sampled on every system clock. They can instead be captured only on the rising or the falling edge of a slow external strobe and held between those edges. The pins and the strobe both pass through two-flop synchronizers before use. Each pin can trigger an interrupt on a low level or on a low-to-high transition. A sticky pending flag, cleared only by software, drives the interrupt output.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads zero, pinOe is all zero, irqOut and busAck are low.
- R2: A request (busCyc and busStb high while busAck is low) is acknowledged with busAck high for exactly one cycle, in the cycle after the request is first seen, and the read data is valid with it. The register index is byte address bits [4:2]: 0 control, 1 input, 2 output, 3 output enable, 4 auxiliary select, 5 interrupt mask, 6 trigger polarity. Index 7, any address with nonzero bits [1:0] and any address with higher bits set read zero, and writes to them are dropped.
- R3: A write changes only the bytes whose busSel bit is set (busSel[k] covers data bits 8k+7..8k).
- R4: The output, output-enable, auxiliary, mask and polarity registers read back what was written in bits below PIN_W, and read zero above. pinOe equals the output-enable register.
- R5: Each pinOut bit is auxIn when its auxiliary-select bit is 1, else the output register bit.
- R6: With control bit 0 clear, the input register takes pinIn on every clock, three clock edges after the pins change. Writes to the input register are ignored.
- R7: With control bit 0 set and control bit 1 clear, the input register takes the synchronized pins only on a rising edge of extClk and holds its value otherwise.
- R8: With control bits 0 and 1 set, the input register takes the pins only on a falling edge of extClk.
- R9: With control bit 2 set, a mask bit of 1 and a polarity bit of 0, a low input register bit sets the pending flag (control bit 3) and raises irqOut.
- R10: With polarity bit 1, only a 0-to-1 change of the input register bit sets the pending flag. A steady high or a falling edge does not.
- R11: No pending flag is set while control bit 2 is clear or the pin's mask bit is clear.
- R12: The pending flag stays set until a control write with busSel[0] set and bit 3 clear. Writing bit 3 as 1 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| busCyc | input | 1 | Bus cycle active |
| busStb | input | 1 | Bus strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busSel | input | 4 | Byte-lane selects |
| busAdr | input | ADDR_W | Byte address |
| busDatIn | input | 32 | Write data |
| busDatOut | output | 32 | Read data, valid with busAck |
| busAck | output | 1 | Transfer acknowledge |
| irqOut | output | 1 | Interrupt request (pending flag) |
| pinIn | input | PIN_W | Pin levels from the pads |
| auxIn | input | PIN_W | Alternate output sources |
| extClk | input | 1 | External sampling strobe |
| pinOut | output | PIN_W | Values driven to the pads |
| pinOe | output | PIN_W | Per-pin driver enable |

## Verification
The bench builds the port with PIN_W = 12 and ADDR_W = 5. The narrow width puts twenty unused bits in every pin-wide register, so the bench can check that they read zero and drop writes. It also makes the byte-lane test hit a lane that is only partly filled. With five address bits, index 7 and misaligned addresses are reachable, and their reads and dropped writes are checked against a model that tracks synchronizer delay, edge sampling and the sticky pending flag clock by clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL = 3'd0,
    IDX_IN   = 3'd1,
    IDX_OUT  = 3'd2,
    IDX_OE   = 3'd3,
    IDX_AUX  = 3'd4,
    IDX_MASK = 3'd5,
    IDX_POL  = 3'd6,
    IDX_NONE = 3'd7
  } regIdx_e;

  // control register bit positions
  localparam int CTRL_EXT   = 0;
  localparam int CTRL_FALL  = 1;
  localparam int CTRL_IRQEN = 2;
  localparam int CTRL_PEND  = 3;

  // strobes from the bus control to the datapath
  typedef struct packed {
    logic              go;      // request accepted this cycle
    logic              wr;      // write request accepted this cycle
    regIdx_e           idx;     // decoded register slot
    logic [LANES-1:0]  laneEn;  // byte lanes
    logic [DATA_W-1:0] wrData;
  } busStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic [LANES-1:0]  busSel,
  input  logic [ADDR_W-1:0] busAdr,
  input  logic [DATA_W-1:0] busDatIn,
  output logic              busAck,
  output busStrobe_t        strb
);
  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic ackQ;
  logic req;
  logic hiClear;
  logic alignOk;

  generate
    if (ADDR_W > IDX_MSB + 1) begin : g_hiBits
      assign hiClear = ~|busAdr[ADDR_W-1:IDX_MSB+1];
    end else begin : g_noHiBits
      assign hiClear = 1'b1;
    end
  endgenerate

  assign alignOk = (busAdr[IDX_LSB-1:0] == '0);
  assign req     = busCyc & busStb & ~ackQ;

  always_comb begin
    strb.go     = req;
    strb.wr     = req & busWe;
    strb.idx    = (hiClear && alignOk) ? regIdx_e'(busAdr[IDX_MSB:IDX_LSB]) : IDX_NONE;
    strb.laneEn = busSel;
    strb.wrData = busDatIn;
  end

  always_ff @(posedge clk) begin
    if (rst) ackQ <= 1'b0;
    else     ackQ <= req;
  end

  assign busAck = ackQ;

  p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    (busCyc && busStb && !busAck) |=> busAck);
  p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
    busAck |=> !busAck);
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  busStrobe_t        strb,
  input  logic [PIN_W-1:0]  pinIn,
  input  logic [PIN_W-1:0]  auxIn,
  input  logic              extClk,
  output logic [DATA_W-1:0] busDatOut,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic              irqOut
);
  logic [PIN_W-1:0] outQ, oeQ, auxQ, maskQ, polQ;
  logic [PIN_W-1:0] inQ, prevInQ, pinS1, pinS2;
  logic             extS1, extS2, extS3;
  logic             extModeQ, fallQ, irqEnQ, pendQ;
  logic             extRise, extFall, sampleNow;
  logic [PIN_W-1:0] trigHit;
  logic             irqEvent;
  logic [DATA_W-1:0] rdMux;
  logic             ctrlWr;

  function automatic logic [PIN_W-1:0] laneMerge(input logic [PIN_W-1:0] old,
                                                 input logic [DATA_W-1:0] data,
                                                 input logic [LANES-1:0] lanes);
    logic [PIN_W-1:0] res;
    res = old;
    for (int b = 0; b < PIN_W; b++)
      if (lanes[b/8]) res[b] = data[b];
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [PIN_W-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PIN_W-1:0] = v;
    return w;
  endfunction

  // synchronizers and external edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      pinS1 <= '0; pinS2 <= '0;
      extS1 <= 1'b0; extS2 <= 1'b0; extS3 <= 1'b0;
    end else begin
      pinS1 <= pinIn; pinS2 <= pinS1;
      extS1 <= extClk; extS2 <= extS1; extS3 <= extS2;
    end
  end

  assign extRise   = extS2 & ~extS3;
  assign extFall   = ~extS2 & extS3;
  assign sampleNow = ~extModeQ | (fallQ ? extFall : extRise);

  always_ff @(posedge clk) begin
    if (rst) begin
      inQ <= '0; prevInQ <= '0;
    end else begin
      prevInQ <= inQ;
      if (sampleNow) inQ <= pinS2;
    end
  end

  // software registers
  always_ff @(posedge clk) begin
    if (rst) begin
      outQ <= '0; oeQ <= '0; auxQ <= '0; maskQ <= '0; polQ <= '0;
    end else if (strb.wr) begin
      case (strb.idx)
        IDX_OUT:  outQ  <= laneMerge(outQ,  strb.wrData, strb.laneEn);
        IDX_OE:   oeQ   <= laneMerge(oeQ,   strb.wrData, strb.laneEn);
        IDX_AUX:  auxQ  <= laneMerge(auxQ,  strb.wrData, strb.laneEn);
        IDX_MASK: maskQ <= laneMerge(maskQ, strb.wrData, strb.laneEn);
        IDX_POL:  polQ  <= laneMerge(polQ,  strb.wrData, strb.laneEn);
        default: ;
      endcase
    end
  end

  assign ctrlWr = strb.wr && (strb.idx == IDX_CTRL) && strb.laneEn[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      extModeQ <= 1'b0; fallQ <= 1'b0; irqEnQ <= 1'b0;
    end else if (ctrlWr) begin
      extModeQ <= strb.wrData[CTRL_EXT];
      fallQ    <= strb.wrData[CTRL_FALL];
      irqEnQ   <= strb.wrData[CTRL_IRQEN];
    end
  end

  // per-pin trigger and output selection
  genvar g;
  generate
    for (g = 0; g < PIN_W; g++) begin : g_pin
      assign trigHit[g] = polQ[g] ? (inQ[g] & ~prevInQ[g]) : ~inQ[g];
      assign pinOut[g]  = auxQ[g] ? auxIn[g] : outQ[g];
    end
  endgenerate

  assign irqEvent = irqEnQ & |(trigHit & maskQ);

  always_ff @(posedge clk) begin
    if (rst)                                  pendQ <= 1'b0;
    else if (irqEvent)                        pendQ <= 1'b1;
    else if (ctrlWr && !strb.wrData[CTRL_PEND]) pendQ <= 1'b0;
  end

  // read path
  always_comb begin
    rdMux = '0;
    case (strb.idx)
      IDX_CTRL: begin
        rdMux[CTRL_EXT]   = extModeQ;
        rdMux[CTRL_FALL]  = fallQ;
        rdMux[CTRL_IRQEN] = irqEnQ;
        rdMux[CTRL_PEND]  = pendQ;
      end
      IDX_IN:   rdMux = widen(inQ);
      IDX_OUT:  rdMux = widen(outQ);
      IDX_OE:   rdMux = widen(oeQ);
      IDX_AUX:  rdMux = widen(auxQ);
      IDX_MASK: rdMux = widen(maskQ);
      IDX_POL:  rdMux = widen(polQ);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          busDatOut <= '0;
    else if (strb.go) busDatOut <= rdMux;
  end

  assign pinOe  = oeQ;
  assign irqOut = pendQ;

  p_oe_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(strb.wr && strb.idx == IDX_OE) |=> $stable(pinOe));
  p_ext_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (extModeQ && !sampleNow) |=> $stable(inQ));
  p_pend_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(irqOut) |-> $past(irqEnQ));
  p_pend_clear_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(irqOut) |-> $past(ctrlWr && !strb.wrData[CTRL_PEND]));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic [LANES-1:0]  busSel,
  input  logic [ADDR_W-1:0] busAdr,
  input  logic [DATA_W-1:0] busDatIn,
  output logic [DATA_W-1:0] busDatOut,
  output logic              busAck,
  output logic              irqOut,
  input  logic [PIN_W-1:0]  pinIn,
  input  logic [PIN_W-1:0]  auxIn,
  input  logic              extClk,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe
);
  busStrobe_t strb;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busSel(busSel), .busAdr(busAdr), .busDatIn(busDatIn),
    .busAck(busAck), .strb(strb)
  );

  gpio_port_dp #(.PIN_W(PIN_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .pinIn(pinIn), .auxIn(auxIn),
    .extClk(extClk), .busDatOut(busDatOut), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );
endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  localparam int W = 12;
  localparam int AW = 5;

  logic clk = 0, rst = 1;
  logic busCyc = 0, busStb = 0, busWe = 0;
  logic [3:0] busSel = 0;
  logic [AW-1:0] busAdr = 0;
  logic [31:0] busDatIn = 0, busDatOut;
  logic busAck, irqOut, extClk = 0;
  logic [W-1:0] pinIn = 0, auxIn = 0, pinOut, pinOe;

  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  gpio_port #(.PIN_W(W), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busSel(busSel), .busAdr(busAdr), .busDatIn(busDatIn), .busDatOut(busDatOut),
    .busAck(busAck), .irqOut(irqOut), .pinIn(pinIn), .auxIn(auxIn),
    .extClk(extClk), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit mExt, mFall, mEn, mPend, mAck, mExtPrev;
  logic [W-1:0] mOut, mOe, mAux, mMask, mPol, mIn, mPrev;
  logic [31:0] mDat;
  logic [W-1:0] pinQ[$];
  bit extQ[$];

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [31:0] d,
                                         input logic [3:0] s);
    logic [W-1:0] r = old;
    for (int b = 0; b < W; b++) if (s[b/8]) r[b] = d[b];
    return r;
  endfunction

  function automatic logic [31:0] mRead(input logic [AW-1:0] a);
    logic [31:0] r = 0;
    if (a[1:0] != 0) return 0;
    case (a[4:2])
      0: r = {28'b0, mPend, mEn, mFall, mExt};
      1: r = 32'(mIn);
      2: r = 32'(mOut);
      3: r = 32'(mOe);
      4: r = 32'(mAux);
      5: r = 32'(mMask);
      6: r = 32'(mPol);
      default: r = 0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin : model
    logic [W-1:0] syn;
    bit es, smp, evt, req;
    logic [31:0] rdv;
    if (rst) begin
      mExt = 0; mFall = 0; mEn = 0; mPend = 0; mAck = 0; mExtPrev = 0;
      mOut = 0; mOe = 0; mAux = 0; mMask = 0; mPol = 0; mIn = 0; mPrev = 0; mDat = 0;
      pinQ = {W'(0), W'(0)};
      extQ = {1'b0, 1'b0};
    end else begin
      syn = pinQ[0];
      es = extQ[0];
      smp = !mExt || (mFall ? (!es && mExtPrev) : (es && !mExtPrev));
      evt = mEn && ((mMask & ((mPol & mIn & ~mPrev) | (~mPol & ~mIn))) != 0);
      req = busCyc && busStb && !mAck;
      rdv = mRead(busAdr);
      mExtPrev = es;
      mPrev = mIn;
      if (smp) mIn = syn;
      if (evt) mPend = 1;
      else if (req && busWe && busAdr == 0 && busSel[0] && !busDatIn[3]) mPend = 0;
      if (req && busWe && busAdr[1:0] == 0) begin
        case (busAdr[4:2])
          0: if (busSel[0]) begin mExt = busDatIn[0]; mFall = busDatIn[1]; mEn = busDatIn[2]; end
          2: mOut  = merge(mOut,  busDatIn, busSel);
          3: mOe   = merge(mOe,   busDatIn, busSel);
          4: mAux  = merge(mAux,  busDatIn, busSel);
          5: mMask = merge(mMask, busDatIn, busSel);
          6: mPol  = merge(mPol,  busDatIn, busSel);
          default: ;
        endcase
      end
      if (req) mDat = rdv;
      mAck = req;
      void'(pinQ.pop_front()); pinQ.push_back(pinIn);
      void'(extQ.pop_front()); extQ.push_back(extClk);
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 pinOut model", 32'(pinOut), 32'((mAux & auxIn) | (~mAux & mOut)));
      chk("R4 pinOe model", 32'(pinOe), 32'(mOe));
      chk("R9 irqOut model", 32'(irqOut), 32'(mPend));
      chk("R2 busAck model", 32'(busAck), 32'(mAck));
      if (busAck) chk("R2 busDatOut model", busDatOut, mDat);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [3:0] s, output logic [31:0] q);
    @(negedge clk);
    busCyc = 1; busStb = 1; busWe = we; busAdr = a; busDatIn = d; busSel = s;
    @(negedge clk);
    while (!busAck) @(negedge clk);
    q = busDatOut;
    busCyc = 0; busStb = 0; busWe = 0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] s = 4'hF);
    logic [31:0] q;
    xfer(1, AW'(idx << 2), d, s, q);
  endtask

  task automatic rdChk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] q;
    xfer(0, a, 0, 4'hF, q);
    chk(tag, q, exp);
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitClk(3);
    rst = 0;
    waitClk(1);
    // R1 reset state
    for (int i = 0; i < 8; i++) rdChk("R1 reset read", AW'(i << 2), 0);
    chk("R1 pinOe reset", 32'(pinOe), 0);
    chk("R1 irqOut reset", 32'(irqOut), 0);

    // R4 readback and pin enables, upper bits dropped
    wr(2, 32'h0000_0ABC);
    rdChk("R4 out readback", 5'h08, 32'h0000_0ABC);
    wr(3, 32'hFFFF_FFFF);
    rdChk("R4 oe readback", 5'h0C, 32'h0000_0FFF);
    chk("R4 pinOe", 32'(pinOe), 32'hFFF);

    // R3 byte lanes
    wr(2, 32'h0000_0123);
    wr(2, 32'hFFFF_FFFF, 4'b0010);
    rdChk("R3 lane merge", 5'h08, 32'h0000_0F23);

    // R5 auxiliary mux
    auxIn = 12'h555;
    wr(4, 32'h0000_00F0);
    waitClk(1);
    chk("R5 aux mux", 32'(pinOut), 32'hF53);

    // R2 unmapped slot and misaligned access; R6 input write ignored
    wr(7, 32'hFFFF_FFFF);
    rdChk("R2 slot 7 reads zero", 5'h1C, 0);
    rdChk("R2 misaligned reads zero", 5'h09, 0);
    wr(1, 32'hFFFF_FFFF);
    rdChk("R6 input write ignored", 5'h04, 0);

    // R6 system-clock sampling
    pinIn = 12'h3A5;
    waitClk(4);
    rdChk("R6 sysclk sample", 5'h04, 32'h3A5);

    // R7 external rising edge
    wr(0, 32'h1);
    pinIn = 12'h111;
    waitClk(6);
    rdChk("R7 hold without edge", 5'h04, 32'h3A5);
    extClk = 1;
    waitClk(6);
    rdChk("R7 rising capture", 5'h04, 32'h111);
    pinIn = 12'h222;
    waitClk(3);
    extClk = 0;
    waitClk(6);
    rdChk("R7 falling ignored", 5'h04, 32'h111);

    // R8 external falling edge
    wr(0, 32'h3);
    pinIn = 12'h0F0;
    waitClk(3);
    extClk = 1;
    waitClk(6);
    rdChk("R8 rising ignored", 5'h04, 32'h111);
    extClk = 0;
    waitClk(6);
    rdChk("R8 falling capture", 5'h04, 32'h0F0);

    // R11, R9, R12 level-low interrupts
    wr(0, 32'h0);
    pinIn = 12'hFFE;
    wr(5, 32'h1);
    waitClk(6);
    chk("R11 global enable off", 32'(irqOut), 0);
    wr(0, 32'h4);
    waitClk(3);
    chk("R9 level-low raises irq", 32'(irqOut), 1);
    rdChk("R9 pending bit", 5'h00, 32'hC);
    pinIn = 12'hFFF;
    waitClk(6);
    chk("R12 sticky", 32'(irqOut), 1);
    wr(0, 32'hC);
    waitClk(2);
    chk("R12 write one keeps", 32'(irqOut), 1);
    wr(0, 32'h4);
    waitClk(2);
    chk("R12 cleared", 32'(irqOut), 0);
    wr(5, 32'h0);
    pinIn = 12'hFFE;
    waitClk(6);
    chk("R11 mask off", 32'(irqOut), 0);

    // R10 rising-edge interrupts
    wr(6, 32'h2);
    wr(5, 32'h2);
    pinIn = 12'hFFD;
    waitClk(6);
    chk("R10 low level no trigger", 32'(irqOut), 0);
    pinIn = 12'hFFF;
    waitClk(6);
    chk("R10 rising trigger", 32'(irqOut), 1);
    wr(0, 32'h4);
    waitClk(6);
    chk("R10 steady high no retrigger", 32'(irqOut), 0);
    rdChk("R12 pending read clear", 5'h00, 32'h4);

    waitClk(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule